// File: doc/BRIEF.md
# Warp Request Activity Counters

This block sits beside the load-store path of a SIMT core and observes each warp memory request: a request strobe, one valid bit per lane and one address per lane. It keeps two running performance totals. The first is the sum, over every accepted request, of how many lanes were active. The second is the number of accepted requests in which every active lane pointed at the same address as lane 0. A combinational flag that marks such uniform requests is also driven out, so neighbouring logic can use the same decision.

Both totals are plain saturating accumulators. They clear on a synchronous active-low reset and stop at their maximum value instead of wrapping. Software averaging and readout sit outside this block.

Top module: `wrq_activity_counters`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `active_total` and `dup_total` become 0 after that edge.
- R2: On a clock edge where `req_valid` is high, `active_total` grows by the number of set bits in `lane_mask` (bit i is lane i).
- R3: On a clock edge where `req_valid` is low, neither counter changes, whatever the mask and addresses are.
- R4: `dup_flag` is high exactly when `lane_mask` is nonzero and every lane i with its mask bit set has `lane_addr[i*ADDR_W +: ADDR_W]` equal to the lane 0 field `lane_addr[ADDR_W-1:0]`; lane 0's address field is the reference even when lane 0 is inactive.
- R5: The address of a lane whose mask bit is clear has no effect on `dup_flag`.
- R6: A request with only lane 0 active (mask 0001 for four lanes) gives `dup_flag` high.
- R7: A request with an all-zero mask gives `dup_flag` low.
- R8: `dup_total` increments by one on a clock edge exactly when `req_valid` and `dup_flag` are both high.
- R9: Each counter saturates: an increment that would pass 2^CNT_W-1 leaves the counter at 2^CNT_W-1, and it stays there.
- R10: When a request is both valid and uniform, both counters update on the same edge, each by its own amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A warp request is presented this cycle |
| lane_mask | input | LANES | Per-lane active bit, bit i for lane i |
| lane_addr | input | LANES*ADDR_W | Per-lane addresses, lane i in bits i*ADDR_W upward |
| dup_flag | output | 1 | All active lanes share lane 0's address |
| active_total | output | CNT_W | Saturating sum of active lanes over valid requests |
| dup_total | output | CNT_W | Saturating count of valid uniform requests |

## Verification
The two functions that meet in one cycle are the lane popcount accumulation and the uniform-request count: a valid request whose active lanes all share lane 0's address must move both totals on the same edge, and a valid non-uniform one must move only the first. The bench walks a table of masks and address sets, each valid, and compares both totals against running sums kept in the bench after every edge. A second instance with a narrow counter width is driven by the same stream so that the final step of the accumulation overshoots its ceiling while the uniform count is still climbing, and both are judged against the saturated values.

// File: rtl/wrq_pkg.sv
// Package: shared defaults and a width helper for the warp request counters.
// Assumes: nothing beyond standard elaboration-time arithmetic.
package wrq_pkg;
    localparam int LANES_DEF  = 4;
    localparam int ADDR_W_DEF = 32;
    localparam int CNT_W_DEF  = 64;

    // Width needed to hold a count from 0 up to n inclusive.
    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/wrq_popcount.sv
// Module: wrq_popcount
// Counts the set bits of a lane mask, purely combinational.
// Assumes: OUT_W is wide enough to hold WIDTH.
module wrq_popcount #(
    parameter int WIDTH = 4,
    parameter int OUT_W = 3
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic [OUT_W-1:0] count_out
);
    // Sum the mask bits one at a time.
    always_comb begin
        count_out = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count_out = count_out + OUT_W'(bits_in[i]);
        end
    end
endmodule

// File: rtl/wrq_dup_detect.sv
// Module: wrq_dup_detect
// Flags a request whose active lanes all carry lane 0's address.
// Assumes: lane i address occupies bits i*ADDR_W upward; an empty mask is never uniform.
module wrq_dup_detect #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0]        mask_in,
    input  logic [LANES*ADDR_W-1:0] addr_in,
    output logic                    uniform_out
);
    logic [ADDR_W-1:0] ref_addr;
    logic [LANES-1:0]  lane_ok;

    assign ref_addr = addr_in[ADDR_W-1:0];

    // One comparator per lane; an inactive lane always agrees.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] = !mask_in[g] || (addr_in[g*ADDR_W +: ADDR_W] == ref_addr);
    end

    // Uniform only if some lane is active and none disagrees.
    always_comb begin
        uniform_out = (|mask_in) && (&lane_ok);
    end
endmodule

// File: rtl/wrq_sat_counter.sv
// Module: wrq_sat_counter
// Accumulates an increment when enabled, clamping at the all-ones value.
// Assumes: INC_W <= CNT_W; synchronous active-low reset clears to zero.
module wrq_sat_counter #(
    parameter int CNT_W = 64,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum_ext;

    // Widened sum so an overshoot is visible before clamping.
    always_comb begin
        sum_ext = {1'b0, cnt} + (CNT_W + 1)'(inc);
    end

    // Register the clamped total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (sum_ext > MAX_EXT) ? MAX_EXT[CNT_W-1:0] : sum_ext[CNT_W-1:0];
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (cnt >= $past(cnt)));                                         // R9
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX_EXT[CNT_W-1:0]) |=> (cnt == MAX_EXT[CNT_W-1:0]));        // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));                                               // R3
endmodule

// File: rtl/wrq_activity_counters.sv
// Module: wrq_activity_counters (top)
// Observes warp memory requests and keeps a saturating active-lane total
// and a saturating count of requests whose active lanes share lane 0's address.
// Assumes: one request per cycle at most, qualified by req_valid.
module wrq_activity_counters #(
    parameter int LANES  = wrq_pkg::LANES_DEF,
    parameter int ADDR_W = wrq_pkg::ADDR_W_DEF,
    parameter int CNT_W  = wrq_pkg::CNT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    output logic                    dup_flag,
    output logic [CNT_W-1:0]        active_total,
    output logic [CNT_W-1:0]        dup_total
);
    localparam int POP_W = wrq_pkg::count_width(LANES);

    logic [POP_W-1:0] lane_pop;
    logic             dup_hit;

    wrq_popcount #(.WIDTH(LANES), .OUT_W(POP_W)) u_pop (
        .bits_in   (lane_mask),
        .count_out (lane_pop)
    );

    wrq_dup_detect #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dup (
        .mask_in     (lane_mask),
        .addr_in     (lane_addr),
        .uniform_out (dup_flag)
    );

    // A uniform request counts only when it is actually issued.
    always_comb begin
        dup_hit = req_valid && dup_flag;
    end

    wrq_sat_counter #(.CNT_W(CNT_W), .INC_W(POP_W)) u_act_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (req_valid),
        .inc   (lane_pop),
        .cnt   (active_total)
    );

    wrq_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_dup_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (dup_hit),
        .inc   (1'b1),
        .cnt   (dup_total)
    );

    AST_EMPTY_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mask == '0) |-> !dup_flag);                                    // R7
    AST_SOLO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mask == LANES'(1)) |-> dup_flag);                              // R6
    AST_DUP_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dup_flag) |=> $stable(dup_total));                    // R8
    AST_EMPTY_NO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lane_mask == '0) |=> $stable(active_total));          // R2
endmodule

// File: tb/wrq_activity_counters_tb.sv
module wrq_activity_counters_tb;
    localparam int LANES  = 4;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 64;
    localparam int SAT_W  = 4;

    typedef struct packed {
        logic [3:0]   mask;
        logic [127:0] addr;
        logic         dup;
        logic [2:0]   pop;
    } vec_t;

    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0000_2040;

    // addr = {lane3, lane2, lane1, lane0}
    localparam vec_t TBL [8] = '{
        '{4'b1111, {A, A, A, A}, 1'b1, 3'd4},   // all same
        '{4'b1111, {B, A, A, A}, 1'b0, 3'd4},   // lane3 differs
        '{4'b0001, {B, B, B, A}, 1'b1, 3'd1},   // only lane0 (R6)
        '{4'b0000, {A, A, A, A}, 1'b0, 3'd0},   // empty (R7)
        '{4'b1011, {A, B, A, A}, 1'b1, 3'd3},   // inactive lane2 differs (R5)
        '{4'b1010, {A, A, B, A}, 1'b0, 3'd2},   // active lane1 differs
        '{4'b0110, {B, A, A, A}, 1'b1, 3'd2},   // lane0 inactive but reference
        '{4'b1000, {B, A, A, A}, 1'b0, 3'd1}    // lone lane3 differs from lane0
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic [LANES-1:0]        lane_mask = '0;
    logic [LANES*ADDR_W-1:0] lane_addr = '0;
    logic                    dup_flag, dup_flag_s;
    logic [CNT_W-1:0]        active_total, dup_total;
    logic [SAT_W-1:0]        sat_act, sat_dup;

    int errors = 0;
    int checks = 0;
    longint exp_act = 0;
    longint exp_dup = 0;

    always #5 clk = ~clk;

    wrq_activity_counters #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .lane_mask (lane_mask), .lane_addr (lane_addr),
        .dup_flag (dup_flag), .active_total (active_total), .dup_total (dup_total)
    );

    wrq_activity_counters #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(SAT_W)) u_sat (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .lane_mask (lane_mask), .lane_addr (lane_addr),
        .dup_flag (dup_flag_s), .active_total (sat_act), .dup_total (sat_dup)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at negedge, let the edge pass, sample at the next negedge.
    task automatic step(input logic v, input logic [3:0] m, input logic [127:0] a);
        req_valid = v;
        lane_mask = m;
        lane_addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 active reset", active_total, 0);
        check("R1 dup reset", dup_total, 0);
        rst_n = 1'b1;

        // Table walk: flag checked before the edge, totals after it.
        for (int i = 0; i < 8; i++) begin
            req_valid = 1'b1;
            lane_mask = TBL[i].mask;
            lane_addr = TBL[i].addr;
            #1;
            check($sformatf("R4 flag vec %0d", i), dup_flag, TBL[i].dup);
            exp_act += TBL[i].pop;
            if (TBL[i].dup) exp_dup++;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R2/R10 active vec %0d", i), active_total, exp_act);
            check($sformatf("R8/R10 dup vec %0d", i), dup_total, exp_dup);
        end

        // R3: invalid uniform full request leaves both totals alone.
        step(1'b0, 4'b1111, {A, A, A, A});
        check("R3 active idle", active_total, exp_act);
        check("R3 dup idle", dup_total, exp_dup);
        check("R4 flag while idle", dup_flag, 1);

        // R5: inactive-lane address change does not alter the flag.
        lane_mask = 4'b0011;
        lane_addr = {B, B, A, A};
        #1;
        check("R5 inactive lanes", dup_flag, 1);
        lane_addr = {A, A, B, A};
        #1;
        check("R4 active lane1 mismatch", dup_flag, 0);

        // Saturation run on a fresh reset: 20 uniform full-mask requests.
        rst_n = 1'b0;
        step(1'b0, 4'b0000, '0);
        check("R1 sat reset", sat_act, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) step(1'b1, 4'b1111, {A, A, A, A});
        check("R10 narrow active 12", sat_act, 12);
        check("R10 narrow dup 3", sat_dup, 3);
        step(1'b1, 4'b1111, {A, A, A, A});
        check("R9 overshoot clamps", sat_act, 15);
        check("R10 dup still counts", sat_dup, 4);
        for (int k = 0; k < 16; k++) step(1'b1, 4'b1111, {A, A, A, A});
        check("R9 active held", sat_act, 15);
        check("R9 dup clamps", sat_dup, 15);
        check("R2 wide active 80", active_total, 80);
        check("R8 wide dup 20", dup_total, 20);

        // R1 again: mid-run reset clears the wide counters.
        rst_n = 1'b0;
        step(1'b1, 4'b1111, {A, A, A, A});
        check("R1 active cleared", active_total, 0);
        check("R1 dup cleared", dup_total, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule